// File: doc/BRIEF.md
# Supervisor Reset Release Sequencer

This block owns the active-low system reset of a board supervisor. It watches four digitized supply-good flags and the four completion flags of the per-channel delay timers that sit beside it. It keeps the system reset asserted until all eight flags are high. It then runs one more programmable hold-off before it lets reset go. A 2-bit select input chooses the hold-off. Time is measured in pulses of an external timebase tick, and a parameter gives the number of ticks per millisecond.

An active-low manual reset pin is synchronized and filtered by width. A pulse that is too short is dropped. A pulse held long enough asserts reset and raises a hold request towards all four channel timers, which then restart their own delays. After the pin is released, reset is released only once every channel reports done again and the full hold-off has elapsed once more.

Top module: `rstrel_seq`

## Requirements
- R1: After the power-on reset `rst_n` is deasserted, `sys_rst_n` is 0 and `chan_hold` is 4'h0. `sys_rst_n` stays 0 while any bit of `sup_good` or `chan_done` is 0.
- R2: Let E0 be the first clock edge that samples all of `sup_good` and `chan_done` high with no manual reset active. `sys_rst_n` rises on the edge that takes in the N-th tick after E0, where N is the selected hold-off in ticks.
- R3: `dly_code` selects the hold-off as a number of milliseconds times `TICKS_PER_MS` ticks: 2'b00 gives 100, 2'b01 gives 500, 2'b10 gives 1000 and 2'b11 gives 5000.
- R4: When any `sup_good` or `chan_done` bit is low at a clock edge, `sys_rst_n` is 0 after that same edge.
- R5: If a flag drops while the hold-off is counting, the count is discarded. A new full hold-off starts at the edge where all flags are sampled high again.
- R6: `dly_code` is captured at E0. A change to `dly_code` during the count has no effect on when `sys_rst_n` rises.
- R7: Only clock edges that see `tick` high advance the hold-off. The release moves later by one cycle for each counting cycle with `tick` low.
- R8: A low pulse on `mr_n` that lasts fewer than `MR_MIN_CYC` consecutive synchronized samples is ignored. `sys_rst_n` and `chan_hold` keep their values.
- R9: When `mr_n` is low for `MR_MIN_CYC` consecutive synchronized samples, `chan_hold` becomes 4'hF and `sys_rst_n` becomes 0. Both hold for as long as `mr_n` stays low, even with all flags high.
- R10: After `mr_n` returns high, `chan_hold` returns to 4'h0 while `sys_rst_n` is still 0. Reset is then released only after all `chan_done` bits are high again and a full hold-off has elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase pulse, one clock wide, TICKS_PER_MS per millisecond |
| dly_code | input | 2 | Release hold-off select |
| sup_good | input | 4 | Digitized supply-in-range flags |
| chan_done | input | 4 | Per-channel delay completion flags |
| mr_n | input | 1 | Manual reset pin, active low, asynchronous |
| chan_hold | output | 4 | Request forcing all channel outputs back to asserted |
| sys_rst_n | output | 1 | Registered system reset, active low |

## Verification
The sequencer holds little state: a count, a captured code, a phase and the manual-reset filter. A wrong value in any of them shows first in when `sys_rst_n` rises.

- A count that is not cleared on a dropped flag, or a code that is sampled again mid-count, moves the release edge by a known number of cycles. This is visible on the first release after the fault.
- A bad filter count shows up in two ways. A short pulse asserts reset within a few cycles of the pulse, or a long press fails to raise `chan_hold` within `MR_MIN_CYC` plus the synchronizer depth.
- A phase that fails to return to hold keeps `sys_rst_n` high one cycle after a flag drops.

The bench measures every release against its expected edge, to the cycle.

// File: rtl/rstrel_pkg.sv
package rstrel_pkg;

   typedef enum logic [1:0] {
      SEQ_HOLD  = 2'd0,
      SEQ_COUNT = 2'd1,
      SEQ_REL   = 2'd2
   } seq_st_t;

   localparam int unsigned LONGEST_MS = 5000;

   // hold-off length in milliseconds for a select code
   function automatic int unsigned code_ms(input logic [1:0] code);
      unique case (code)
         2'b00:   code_ms = 100;
         2'b01:   code_ms = 500;
         2'b10:   code_ms = 1000;
         default: code_ms = LONGEST_MS;
      endcase
   endfunction

endpackage

// File: rtl/rstrel_mr_filter.sv
module rstrel_mr_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MR_MIN_CYC  = 625
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mr_n,
   output logic mr_act
);
   localparam int unsigned FW = (MR_MIN_CYC < 2) ? 1 : $clog2(MR_MIN_CYC);
   localparam logic [FW-1:0] LAST = FW'(MR_MIN_CYC - 1);

   logic          mr_s;
   logic [FW-1:0] run_q;
   logic          act_q;

   if (MR_MIN_CYC < 2) begin : g_bad_min
      $error("MR_MIN_CYC must be at least 2");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must not exceed 4");
   end

   if (SYNC_STAGES == 0) begin : g_nosync
      assign mr_s = mr_n;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh_q <= '1;
         else        sh_q <= {sh_q[SYNC_STAGES-2:0], mr_n};
      end
      assign mr_s = sh_q[SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         act_q <= 1'b0;
      end else if (mr_s) begin
         run_q <= '0;
         act_q <= 1'b0;
      end else if (run_q == LAST) begin
         act_q <= 1'b1;
      end else begin
         run_q <= run_q + FW'(1);
      end
   end

   assign mr_act = act_q;
endmodule

// File: rtl/rstrel_dly_timer.sv
module rstrel_dly_timer #(
   parameter int unsigned TICKS_PER_MS = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       run,
   input  logic       tick,
   input  logic [1:0] code,
   output logic       done
);
   import rstrel_pkg::*;

   localparam int unsigned MAX_TICKS = LONGEST_MS * TICKS_PER_MS;
   localparam int unsigned CW        = $clog2(MAX_TICKS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] tgt_q;

   if (TICKS_PER_MS < 1) begin : g_bad_tpm
      $error("TICKS_PER_MS must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         tgt_q <= '0;
      end else if (start) begin
         cnt_q <= '0;
         tgt_q <= CW'(code_ms(code) * TICKS_PER_MS);
      end else if (run && tick) begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign done = run && tick && (cnt_q == (tgt_q - CW'(1)));
endmodule

// File: rtl/rstrel_seq.sv
module rstrel_seq #(
   parameter int unsigned TICKS_PER_MS = 1,
   parameter int unsigned MR_MIN_CYC   = 625,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned NCH          = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] dly_code,
   input  logic [3:0] sup_good,
   input  logic [3:0] chan_done,
   input  logic       mr_n,
   output logic [3:0] chan_hold,
   output logic       sys_rst_n
);
   import rstrel_pkg::*;

   if (NCH != 4) begin : g_bad_nch
      $error("NCH must match the four-bit flag ports");
   end

   seq_st_t st_q, st_d;
   logic    mr_act;
   logic    flags_ok, go;
   logic    t_start, t_run, t_done;
   logic    rst_q;

   rstrel_mr_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .MR_MIN_CYC (MR_MIN_CYC)
   ) u_mr (
      .clk   (clk),
      .rst_n (rst_n),
      .mr_n  (mr_n),
      .mr_act(mr_act)
   );

   assign flags_ok = (&sup_good) && (&chan_done);
   assign go       = flags_ok && !mr_act;

   always_comb begin
      st_d    = st_q;
      t_start = 1'b0;
      unique case (st_q)
         SEQ_HOLD: if (go) begin
            st_d    = SEQ_COUNT;
            t_start = 1'b1;
         end
         SEQ_COUNT: begin
            if (!go)        st_d = SEQ_HOLD;
            else if (t_done) st_d = SEQ_REL;
         end
         SEQ_REL: if (!go) st_d = SEQ_HOLD;
         default: st_d = SEQ_HOLD;
      endcase
   end

   assign t_run = (st_q == SEQ_COUNT) && go;

   rstrel_dly_timer #(
      .TICKS_PER_MS(TICKS_PER_MS)
   ) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(t_start),
      .run  (t_run),
      .tick (tick),
      .code (dly_code),
      .done (t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_HOLD;
         rst_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         rst_q <= (st_d == SEQ_REL);
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_hold
      assign chan_hold[i] = mr_act;
   end

   assign sys_rst_n = rst_q;
endmodule

// File: rtl/rstrel_chk.sv
module rstrel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] sup_good,
   input logic [3:0] chan_done,
   input logic [3:0] chan_hold,
   input logic       sys_rst_n
);
   // R4: a low flag at an edge leaves reset asserted after it
   p_drop_asserts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !((&sup_good) && (&chan_done)) |=> !sys_rst_n);

   // R2: a release only follows an edge with every flag high
   p_rise_needs_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sys_rst_n) |-> $past((&sup_good) && (&chan_done)));

   // R9: a qualified manual reset keeps the system in reset
   p_hold_forces_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|chan_hold) |=> !sys_rst_n);

   // R10: channel holds are dropped while reset is still asserted
   p_hold_drop_in_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_hold[0]) |-> !sys_rst_n);
endmodule

bind rstrel_seq rstrel_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sup_good (sup_good),
   .chan_done(chan_done),
   .chan_hold(chan_hold),
   .sys_rst_n(sys_rst_n)
);

// File: tb/tb_rstrel_seq.sv
module tb_rstrel_seq;
   localparam int TPM  = 1;
   localparam int MINW = 8;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic [1:0] dly_code;
   logic [3:0] sup_good;
   logic [3:0] chan_done;
   logic       mr_n;
   logic [3:0] chan_hold;
   logic       sys_rst_n;

   int total = 0;
   int bad   = 0;
   int edges = 0;
   bit finished = 1'b0;

   int    exp_q[$];
   int    mark_q[$];
   string tag_q[$];

   always #4 clk = ~clk;

   always @(posedge clk) edges <= edges + 1;

   rstrel_seq #(
      .TICKS_PER_MS(TPM),
      .MR_MIN_CYC  (MINW),
      .SYNC_STAGES (SYNC)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .dly_code (dly_code),
      .sup_good (sup_good),
      .chan_done(chan_done),
      .mr_n     (mr_n),
      .chan_hold(chan_hold),
      .sys_rst_n(sys_rst_n)
   );

   function automatic int ticks_of(input logic [1:0] c);
      case (c)
         2'b00:   return 100 * TPM;
         2'b01:   return 500 * TPM;
         2'b10:   return 1000 * TPM;
         default: return 5000 * TPM;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard: expected release distance in edges
   task automatic push_release(input int ticks, input int extra, input string tag);
      exp_q.push_back(ticks + 1 + extra);
      mark_q.push_back(edges);
      tag_q.push_back(tag);
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor side: each rising release is matched to the queue head
   logic prev_rel = 1'b0;
   always @(negedge clk) begin
      if (rst_n === 1'b1 && sys_rst_n === 1'b1 && prev_rel == 1'b0) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 release with nothing expected", 1, 0);
         end else begin
            int e, m;
            string t;
            e = exp_q.pop_front();
            m = mark_q.pop_front();
            t = tag_q.pop_front();
            chk((edges - m) == e, t, edges - m, e);
         end
      end
      prev_rel = (sys_rst_n === 1'b1);
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; tick = 1'b1; dly_code = 2'b00;
      sup_good = 4'h0; chan_done = 4'h0; mr_n = 1'b1;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      chk(sys_rst_n == 1'b0, "R1 reset level after power-on", sys_rst_n, 0);
      chk(chan_hold == 4'h0, "R1 hold after power-on", chan_hold, 0);

      // R1: supplies good but one channel still timing
      sup_good = 4'hF; chan_done = 4'h7;
      idle(300);
      chk(sys_rst_n == 1'b0, "R1 channel not done", sys_rst_n, 0);

      // R2 / R3 code 00
      chan_done = 4'hF;
      push_release(ticks_of(2'b00), 0, "R2 R3 hold-off code 00");
      drain();

      // R4 supply drop
      sup_good = 4'hB;
      idle(1);
      chk(sys_rst_n == 1'b0, "R4 supply drop asserts reset", sys_rst_n, 0);
      dly_code = 2'b01; sup_good = 4'hF;
      push_release(ticks_of(2'b01), 0, "R3 hold-off code 01");
      drain();

      // R4 channel drop
      chan_done = 4'hE;
      idle(1);
      chk(sys_rst_n == 1'b0, "R4 channel drop asserts reset", sys_rst_n, 0);
      dly_code = 2'b10; chan_done = 4'hF;
      push_release(ticks_of(2'b10), 0, "R3 hold-off code 10");
      drain();

      sup_good = 4'h7;
      idle(1);
      dly_code = 2'b11; sup_good = 4'hF;
      push_release(ticks_of(2'b11), 0, "R3 hold-off code 11");
      drain();

      // R5 restart after a mid-count drop
      dly_code = 2'b00;
      sup_good = 4'hD;
      idle(1);
      sup_good = 4'hF;
      idle(60);
      chan_done = 4'h7;
      idle(3);
      chan_done = 4'hF;
      push_release(ticks_of(2'b00), 0, "R5 restart after mid-count drop");
      drain();

      // R6 code change during count ignored
      sup_good = 4'hE;
      idle(1);
      sup_good = 4'hF;
      push_release(ticks_of(2'b00), 0, "R6 code change ignored");
      idle(10);
      dly_code = 2'b11;
      drain();
      dly_code = 2'b00;

      // R7 tick gating
      sup_good = 4'hE;
      idle(1);
      sup_good = 4'hF;
      push_release(ticks_of(2'b00), 40, "R7 only ticks advance");
      idle(20);
      tick = 1'b0;
      idle(40);
      tick = 1'b1;
      drain();

      // R8 short manual pulse
      mr_n = 1'b0;
      idle(MINW - 1);
      mr_n = 1'b1;
      idle(30);
      chk(sys_rst_n == 1'b1, "R8 short pulse keeps reset released", sys_rst_n, 1);
      chk(chan_hold == 4'h0, "R8 short pulse no hold", chan_hold, 0);

      // R9 qualified manual reset
      mr_n = 1'b0;
      idle(MINW + SYNC + 4);
      chk(chan_hold == 4'hF, "R9 hold raised", chan_hold, 15);
      chk(sys_rst_n == 1'b0, "R9 reset asserted", sys_rst_n, 0);
      chan_done = 4'h0;
      idle(20);
      chan_done = 4'hF;
      idle(200);
      chk(sys_rst_n == 1'b0, "R9 reset held while pin low", sys_rst_n, 0);
      chan_done = 4'h0;

      // R10 release sequence after manual reset
      mr_n = 1'b1;
      idle(SYNC + 3);
      chk(chan_hold == 4'h0, "R10 hold dropped", chan_hold, 0);
      chk(sys_rst_n == 1'b0, "R10 reset kept until channels done", sys_rst_n, 0);
      idle(20);
      chk(sys_rst_n == 1'b0, "R10 reset still held", sys_rst_n, 0);
      chan_done = 4'hF;
      push_release(ticks_of(2'b00), 0, "R10 full hold-off after manual reset");
      drain();

      idle(5);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule